// File: doc/BRIEF.md
# 32-bit Integer ALU with Overflow Trap

This block is the combinational arithmetic and logic unit of a load/store RISC datapath. It takes two register operands and a 16-bit immediate. It also takes a 5-bit constant shift field and a 4-bit operation code. From these it produces a 32-bit result, a zero flag for branch-equal decisions, and an overflow-trap output.

When `useImm` is set, the unit builds the second operand from the immediate inside the block. The operation class chooses the extension. Bitwise operations zero-extend the immediate. Every other operation sign-extends it, including the non-trapping add and the unsigned compare.

Add and subtract come in a trapping and a non-trapping form, and only the trapping form can raise the trap. Shifts always move the second register operand, `opB`. The shift distance comes either from the constant field or from the low bits of `opA`. The block has no register file, no instruction decoder and no multiply or divide unit.

Top module: `int_alu32`

## Requirements
- R1: The trapping ops ADD (code 0) and SUB (code 2) return the two's-complement sum or difference modulo 2^32. They assert `ovfTrap` exactly when the signed result overflows. This holds with a register or an immediate second operand.
- R2: The non-trapping ops ADDU (code 1) and SUBU (code 3) return the same wrapped sum or difference as R1. For ADDU, SUBU and every other code, `ovfTrap` is 0.
- R3: The bitwise ops are AND (4), OR (5), XOR (6) and NOR (7). NOR returns the complement of A OR B. None of them raises `ovfTrap`.
- R4: With `useImm`=1, the bitwise ops use the immediate zero-extended to 32 bits. Bits 31..16 of the second operand are 0 even when `imm16[15]` is 1.
- R5: With `useImm`=1, the add, subtract and compare ops (codes 0, 1, 2, 3, 8, 9) use the immediate sign-extended to 32 bits. Bit 15 is copied into bits 31..16.
- R6: SLT (code 8) returns 1 when A is less than B read as signed two's complement, and 0 otherwise. This holds also when A minus B overflows.
- R7: SLTU (code 9) returns 1 when A is less than B read as unsigned, and 0 otherwise. With an immediate, the unsigned compare uses the sign-extended value.
- R8: SLL (10) and SRL (11) shift `opB` by `shamt`, from 0 to 31, and fill the vacated bits with 0.
- R9: SRA (12) shifts `opB` right by `shamt` and fills the vacated bits with `opB[31]`.
- R10: SLLV (13), SRLV (14) and SRAV (15) shift `opB` by `opA[4:0]`. They ignore `opA[31:5]` and `shamt`. No shift op, constant or variable, is affected by `useImm` or `imm16`.
- R11: `zero` is 1 exactly when `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First register operand; also the source of the variable shift distance |
| opB | input | 32 | Second register operand; also the data that shifts move |
| imm16 | input | 16 | Immediate field |
| useImm | input | 1 | Replace opB with the extended immediate for non-shift ops |
| shamt | input | 5 | Constant shift distance |
| aluOp | input | 4 | Operation code (see requirements) |
| result | output | 32 | Operation result |
| zero | output | 1 | Result is all zeros |
| ovfTrap | output | 1 | Signed overflow on a trapping add or subtract |

## Verification
The hardest cases to reach are the ones where the adder's own sign bit gives the wrong answer. One is a signed compare whose difference overflows. The other is a subtract whose second operand is the most negative number, where negating B cannot be represented. The stimulus sets these up directly with operand pairs on opposite sides of the sign boundary, such as 0x7FFFFFFF against 0x80000000 and 0 minus 0x80000000. It also applies sign-bit-set immediates to both the unsigned compare and the bitwise ops, so a wrong extension choice changes the visible result.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDU = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBU = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOR  = 4'd7,
    OP_SLT  = 4'd8,
    OP_SLTU = 4'd9,
    OP_SLL  = 4'd10,
    OP_SRL  = 4'd11,
    OP_SRA  = 4'd12,
    OP_SLLV = 4'd13,
    OP_SRLV = 4'd14,
    OP_SRAV = 4'd15
  } aluOp_e;

  typedef enum logic [1:0] {
    RES_ARITH = 2'd0,
    RES_LOGIC = 2'd1,
    RES_LESS  = 2'd2,
    RES_SHIFT = 2'd3
  } resSel_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logicFn_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic     subtract;     // invert B and carry in one
    logic     trapEn;       // allow overflow to reach the trap output
    logic     immSigned;    // sign-extend the immediate, else zero-extend
    logic     lessUnsigned; // compare as natural numbers
    logicFn_e logicFn;
    logic     shiftRight;
    logic     shiftArith;
    logic     shiftVar;     // distance from operand A
    resSel_e  resSel;
  } aluCtrl_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [3:0] aluOp,
  output aluCtrl_t   ctrl
);

  aluOp_e opCode;
  assign opCode = aluOp_e'(aluOp);

  always_comb begin
    ctrl = '{subtract: 1'b0, trapEn: 1'b0, immSigned: 1'b1,
             lessUnsigned: 1'b0, logicFn: LG_AND, shiftRight: 1'b0,
             shiftArith: 1'b0, shiftVar: 1'b0, resSel: RES_ARITH};
    unique case (opCode)
      OP_ADD:  ctrl.trapEn = 1'b1;
      OP_ADDU: ctrl.trapEn = 1'b0;
      OP_SUB: begin
        ctrl.subtract = 1'b1;
        ctrl.trapEn   = 1'b1;
      end
      OP_SUBU: ctrl.subtract = 1'b1;
      OP_AND, OP_OR, OP_XOR, OP_NOR: begin
        ctrl.immSigned = 1'b0;
        ctrl.resSel    = RES_LOGIC;
        ctrl.logicFn   = logicFn_e'(aluOp[1:0]);
      end
      OP_SLT, OP_SLTU: begin
        ctrl.subtract     = 1'b1;
        ctrl.resSel       = RES_LESS;
        ctrl.lessUnsigned = aluOp[0];
      end
      OP_SLL, OP_SRL, OP_SRA: begin
        ctrl.resSel     = RES_SHIFT;
        ctrl.shiftRight = (opCode != OP_SLL);
        ctrl.shiftArith = (opCode == OP_SRA);
      end
      OP_SLLV, OP_SRLV, OP_SRAV: begin
        ctrl.resSel     = RES_SHIFT;
        ctrl.shiftVar   = 1'b1;
        ctrl.shiftRight = (opCode != OP_SLLV);
        ctrl.shiftArith = (opCode == OP_SRAV);
      end
      default: ctrl.resSel = RES_ARITH;
    endcase
  end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  dataIn,
  input  logic [SHAMT_W-1:0] amount,
  input  logic               shiftRight,
  input  logic               shiftArith,
  output logic [DATA_W-1:0]  dataOut
);

  logic [DATA_W-1:0] revIn;
  logic [DATA_W-1:0] revOut;
  logic [DATA_W-1:0] stage [SHAMT_W+1];
  logic              fillBit;

  assign fillBit  = shiftRight & shiftArith & dataIn[DATA_W-1];

  // Left shifts run through the right-shift network on reversed bits
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign revIn[i]  = dataIn[DATA_W-1-i];
    assign revOut[i] = stage[SHAMT_W][DATA_W-1-i];
  end

  assign stage[0] = shiftRight ? dataIn : revIn;

  for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = amount[s] ? {{STEP{fillBit}}, stage[s][DATA_W-1:STEP]}
                                  : stage[s];
  end

  assign dataOut = shiftRight ? stage[SHAMT_W] : revOut;

endmodule

// File: rtl/alu_dp.sv
module alu_dp
  import alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  aluCtrl_t           ctrl,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic [IMM_W-1:0]   imm16,
  input  logic               useImm,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [DATA_W-1:0]  result,
  output logic               zero,
  output logic               ovfTrap
);

  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] secondOp;
  logic [DATA_W-1:0] bAdj;
  logic [DATA_W:0]   sumWide;
  logic [DATA_W-1:0] sum;
  logic              carryOut;
  logic              rawOvf;
  logic              lessBit;
  logic [DATA_W-1:0] logicRes;
  logic [DATA_W-1:0] shiftRes;
  logic [SHAMT_W-1:0] shiftDist;

  // Immediate extender
  assign immExt   = ctrl.immSigned ? {{EXT_W{imm16[IMM_W-1]}}, imm16}
                                   : {{EXT_W{1'b0}}, imm16};
  assign secondOp = useImm ? immExt : opB;

  // Shared adder: subtract and compare use A + ~B + 1
  assign bAdj     = ctrl.subtract ? ~secondOp : secondOp;
  assign sumWide  = {1'b0, opA} + {1'b0, bAdj} + {{DATA_W{1'b0}}, ctrl.subtract};
  assign sum      = sumWide[DATA_W-1:0];
  assign carryOut = sumWide[DATA_W];
  assign rawOvf   = (opA[DATA_W-1] == bAdj[DATA_W-1]) &&
                    (sum[DATA_W-1] != opA[DATA_W-1]);
  assign lessBit  = ctrl.lessUnsigned ? ~carryOut : (sum[DATA_W-1] ^ rawOvf);

  always_comb begin
    unique case (ctrl.logicFn)
      LG_AND:  logicRes = opA & secondOp;
      LG_OR:   logicRes = opA | secondOp;
      LG_XOR:  logicRes = opA ^ secondOp;
      default: logicRes = ~(opA | secondOp);
    endcase
  end

  assign shiftDist = ctrl.shiftVar ? opA[SHAMT_W-1:0] : shamt;

  alu_shifter #(
    .DATA_W (DATA_W),
    .SHAMT_W(SHAMT_W)
  ) u_shifter (
    .dataIn    (opB),
    .amount    (shiftDist),
    .shiftRight(ctrl.shiftRight),
    .shiftArith(ctrl.shiftArith),
    .dataOut   (shiftRes)
  );

  always_comb begin
    unique case (ctrl.resSel)
      RES_ARITH: result = sum;
      RES_LOGIC: result = logicRes;
      RES_LESS:  result = {{(DATA_W-1){1'b0}}, lessBit};
      default:   result = shiftRes;
    endcase
  end

  assign zero    = ~|result;
  assign ovfTrap = ctrl.trapEn & (ctrl.resSel == RES_ARITH) & rawOvf;

endmodule

// File: rtl/int_alu32.sv
module int_alu32
  import alu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic [IMM_W-1:0]   imm16,
  input  logic               useImm,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic [3:0]         aluOp,
  output logic [DATA_W-1:0]  result,
  output logic               zero,
  output logic               ovfTrap
);

  aluCtrl_t ctrl;

  alu_ctrl u_ctrl (
    .aluOp(aluOp),
    .ctrl (ctrl)
  );

  alu_dp #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W),
    .SHAMT_W(SHAMT_W)
  ) u_dp (
    .ctrl   (ctrl),
    .opA    (opA),
    .opB    (opB),
    .imm16  (imm16),
    .useImm (useImm),
    .shamt  (shamt),
    .result (result),
    .zero   (zero),
    .ovfTrap(ovfTrap)
  );

endmodule

// File: rtl/int_alu32_chk.sv
module int_alu32_chk #(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input logic [DATA_W-1:0]  opA,
  input logic [DATA_W-1:0]  opB,
  input logic [IMM_W-1:0]   imm16,
  input logic               useImm,
  input logic [SHAMT_W-1:0] shamt,
  input logic [3:0]         aluOp,
  input logic [DATA_W-1:0]  result,
  input logic               zero,
  input logic               ovfTrap
);

  logic [DATA_W-1:0] sextImm;
  assign sextImm = {{(DATA_W-IMM_W){imm16[IMM_W-1]}}, imm16};

  always_comb begin
    if (ovfTrap) begin
      AST_TRAP_ONLY_ADD_SUB: assert (aluOp == 4'd0 || aluOp == 4'd2)
        else $error("trap on non-trapping op %0d", aluOp); // R2
    end
    AST_ZERO_FLAG: assert (zero == (result == '0))
      else $error("zero flag mismatch"); // R11
    if (aluOp == 4'd8 || aluOp == 4'd9) begin
      AST_LESS_IS_BOOL: assert (result[DATA_W-1:1] == '0)
        else $error("compare result not 0/1"); // R6
    end
    if (useImm && aluOp == 4'd4) begin
      AST_LOGIC_IMM_ZEXT: assert (result[DATA_W-1:IMM_W] == '0)
        else $error("logical immediate not zero-extended"); // R4
    end
    if (useImm && aluOp == 4'd1) begin
      AST_ARITH_IMM_SEXT: assert (result == opA + sextImm)
        else $error("arith immediate not sign-extended"); // R5
    end
    if (aluOp == 4'd12 && shamt != '0) begin
      AST_SRA_SIGN_FILL: assert (result[DATA_W-1] == opB[DATA_W-1])
        else $error("arith shift lost sign"); // R9
    end
    if (aluOp == 4'd10 && shamt != '0) begin
      AST_SLL_ZERO_FILL: assert (result[0] == 1'b0)
        else $error("left shift filled with one"); // R8
    end
  end

endmodule

bind int_alu32 int_alu32_chk #(
  .DATA_W (DATA_W),
  .IMM_W  (IMM_W),
  .SHAMT_W(SHAMT_W)
) u_chk (
  .opA    (opA),
  .opB    (opB),
  .imm16  (imm16),
  .useImm (useImm),
  .shamt  (shamt),
  .aluOp  (aluOp),
  .result (result),
  .zero   (zero),
  .ovfTrap(ovfTrap)
);

// File: tb/sim_int_alu32.sv
module sim_int_alu32;

  logic        clk = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [15:0] imm16 = '0;
  logic        useImm = 1'b0;
  logic [4:0]  shamt = '0;
  logic [3:0]  aluOp = '0;
  logic [31:0] result;
  logic        zero;
  logic        ovfTrap;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  int_alu32 u0 (
    .opA(opA), .opB(opB), .imm16(imm16), .useImm(useImm),
    .shamt(shamt), .aluOp(aluOp),
    .result(result), .zero(zero), .ovfTrap(ovfTrap)
  );

  task automatic apply(input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] imm,
                       input logic ui, input logic [4:0] sh);
    @(negedge clk);
    aluOp = op; opA = a; opB = b; imm16 = imm; useImm = ui; shamt = sh;
    #2;
  endtask

  task automatic check(input string req, input logic [31:0] expRes,
                       input logic expOvf);
    logic expZero;
    expZero = (expRes == 32'd0);
    checks++;
    if (result !== expRes || zero !== expZero || ovfTrap !== expOvf) begin
      errors++;
      $display("FAIL %s: op=%0d result=%h zero=%b ovf=%b expected result=%h zero=%b ovf=%b",
               req, aluOp, result, zero, ovfTrap, expRes, expZero, expOvf);
    end
  endtask

  task automatic t_idle();
    #1;
    check("R11 idle add of zeros", 32'h0, 1'b0);
  endtask

  task automatic t_trapping();
    apply(4'd0, 32'h7FFF_FFFF, 32'h1, 16'h0, 1'b0, 5'd0);
    check("R1 add pos overflow", 32'h8000_0000, 1'b1);
    apply(4'd0, 32'h8000_0000, 32'h8000_0000, 16'h0, 1'b0, 5'd0);
    check("R1 add neg overflow", 32'h0, 1'b1);
    apply(4'd0, 32'd5, 32'hFFFF_FFFD, 16'h0, 1'b0, 5'd0);
    check("R1 add mixed sign", 32'd2, 1'b0);
    apply(4'd2, 32'h8000_0000, 32'h1, 16'h0, 1'b0, 5'd0);
    check("R1 sub underflow", 32'h7FFF_FFFF, 1'b1);
    apply(4'd2, 32'h0, 32'h8000_0000, 16'h0, 1'b0, 5'd0);
    check("R1 zero minus minint", 32'h8000_0000, 1'b1);
    apply(4'd2, 32'hFFFF_FFFF, 32'h8000_0000, 16'h0, 1'b0, 5'd0);
    check("R1 minus one minus minint", 32'h7FFF_FFFF, 1'b0);
    apply(4'd0, 32'h7FFF_FFFF, 32'h0, 16'h0001, 1'b1, 5'd0);
    check("R1 add immediate overflow", 32'h8000_0000, 1'b1);
  endtask

  task automatic t_nontrapping();
    apply(4'd1, 32'h7FFF_FFFF, 32'h1, 16'h0, 1'b0, 5'd0);
    check("R2 addu wraps silently", 32'h8000_0000, 1'b0);
    apply(4'd3, 32'h8000_0000, 32'h1, 16'h0, 1'b0, 5'd0);
    check("R2 subu wraps silently", 32'h7FFF_FFFF, 1'b0);
    apply(4'd3, 32'h1234, 32'h1234, 16'h0, 1'b0, 5'd0);
    check("R11 subu equal gives zero", 32'h0, 1'b0);
  endtask

  task automatic t_logic();
    apply(4'd4, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0, 1'b0, 5'd0);
    check("R3 and", 32'h00F0_1200, 1'b0);
    apply(4'd5, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0, 1'b0, 5'd0);
    check("R3 or", 32'hFFF0_FF34, 1'b0);
    apply(4'd6, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0, 1'b0, 5'd0);
    check("R3 xor", 32'hFF00_ED34, 1'b0);
    apply(4'd7, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0, 1'b0, 5'd0);
    check("R3 nor", 32'h000F_00CB, 1'b0);
    apply(4'd6, 32'hA5A5_5A5A, 32'hA5A5_5A5A, 16'h0, 1'b0, 5'd0);
    check("R11 xor equal gives zero", 32'h0, 1'b0);
  endtask

  task automatic t_logic_imm();
    apply(4'd5, 32'h1234_0000, 32'hFFFF_FFFF, 16'h8001, 1'b1, 5'd0);
    check("R4 or immediate", 32'h1234_8001, 1'b0);
    apply(4'd4, 32'hFFFF_FFFF, 32'h0, 16'h8000, 1'b1, 5'd0);
    check("R4 and immediate", 32'h0000_8000, 1'b0);
    apply(4'd6, 32'hFFFF_0000, 32'h0, 16'hFFFF, 1'b1, 5'd0);
    check("R4 xor immediate", 32'hFFFF_FFFF, 1'b0);
    apply(4'd7, 32'h0, 32'h0, 16'h8000, 1'b1, 5'd0);
    check("R4 nor immediate", 32'hFFFF_7FFF, 1'b0);
  endtask

  task automatic t_arith_imm();
    apply(4'd1, 32'd10, 32'h0, 16'hFFFF, 1'b1, 5'd0);
    check("R5 addu immediate sign-extended", 32'd9, 1'b0);
    apply(4'd3, 32'd0, 32'h0, 16'h8000, 1'b1, 5'd0);
    check("R5 subu immediate sign-extended", 32'h0000_8000, 1'b0);
  endtask

  task automatic t_compare();
    apply(4'd8, 32'hFFFF_FFFF, 32'h1, 16'h0, 1'b0, 5'd0);
    check("R6 slt minus one vs one", 32'd1, 1'b0);
    apply(4'd9, 32'hFFFF_FFFF, 32'h1, 16'h0, 1'b0, 5'd0);
    check("R7 sltu max vs one", 32'd0, 1'b0);
    apply(4'd8, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 1'b0, 5'd0);
    check("R6 slt overflowing difference", 32'd0, 1'b0);
    apply(4'd8, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 1'b0, 5'd0);
    check("R6 slt minint vs maxint", 32'd1, 1'b0);
    apply(4'd9, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 1'b0, 5'd0);
    check("R7 sltu across sign bit", 32'd1, 1'b0);
    apply(4'd8, 32'd77, 32'd77, 16'h0, 1'b0, 5'd0);
    check("R6 slt equal", 32'd0, 1'b0);
    apply(4'd8, 32'hFFFF_FFFB, 32'h0, 16'hFFFF, 1'b1, 5'd0);
    check("R6 slt immediate", 32'd1, 1'b0);
    apply(4'd9, 32'd5, 32'h0, 16'hFFFF, 1'b1, 5'd0);
    check("R7 sltu sign-extended immediate", 32'd1, 1'b0);
  endtask

  task automatic t_const_shift();
    apply(4'd10, 32'h0, 32'h8000_0001, 16'h0, 1'b0, 5'd1);
    check("R8 sll by one", 32'h0000_0002, 1'b0);
    apply(4'd10, 32'h0, 32'h1, 16'h0, 1'b0, 5'd31);
    check("R8 sll by 31", 32'h8000_0000, 1'b0);
    apply(4'd11, 32'h0, 32'h8000_0000, 16'h0, 1'b0, 5'd31);
    check("R8 srl by 31", 32'h1, 1'b0);
    apply(4'd11, 32'h0, 32'hDEAD_BEEF, 16'h0, 1'b0, 5'd0);
    check("R8 srl by zero", 32'hDEAD_BEEF, 1'b0);
    apply(4'd12, 32'h0, 32'h8000_0000, 16'h0, 1'b0, 5'd31);
    check("R9 sra negative by 31", 32'hFFFF_FFFF, 1'b0);
    apply(4'd12, 32'h0, 32'h4000_0000, 16'h0, 1'b0, 5'd4);
    check("R9 sra positive", 32'h0400_0000, 1'b0);
    apply(4'd12, 32'h0, 32'hF000_0000, 16'h0, 1'b0, 5'd0);
    check("R9 sra by zero", 32'hF000_0000, 1'b0);
  endtask

  task automatic t_var_shift();
    apply(4'd13, 32'hFFFF_FFE4, 32'h0000_00FF, 16'h0, 1'b0, 5'd9);
    check("R10 sllv low bits only", 32'h0000_0FF0, 1'b0);
    apply(4'd15, 32'h0000_0020, 32'h8000_0000, 16'h0, 1'b0, 5'd3);
    check("R10 srav distance 32 wraps to 0", 32'h8000_0000, 1'b0);
    apply(4'd14, 32'd31, 32'hFFFF_FFFF, 16'h0, 1'b0, 5'd0);
    check("R10 srlv by 31", 32'h1, 1'b0);
    apply(4'd14, 32'd31, 32'hFFFF_FFFF, 16'hFFFF, 1'b1, 5'd7);
    check("R10 srlv ignores immediate and shamt", 32'h1, 1'b0);
    apply(4'd10, 32'h0, 32'd3, 16'h1234, 1'b1, 5'd2);
    check("R10 sll ignores immediate", 32'd12, 1'b0);
  endtask

  initial begin
    t_idle();
    t_trapping();
    t_nontrapping();
    t_logic();
    t_logic_imm();
    t_arith_imm();
    t_compare();
    t_const_shift();
    t_var_shift();
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule